// File: doc/BRIEF.md
# Circle Hough Voter with Eight-Way Symmetric Sampling

This block searches a binary edge map for the circle that best matches the edges in it. A single start pulse loads inclusive ranges for the centre column, the centre row and the radius. The block then visits every candidate circle in those ranges. For each candidate it runs a midpoint circle generator. Each step of the generator yields one offset in the first octant. That offset is mirrored into eight points around the candidate centre. The edge bits at the eight points are read at once through eight read lanes and added to a vote for that circle.

When a candidate's outline is complete, its vote is compared with the best vote found so far. The winning centre, radius and vote stay on the outputs after the search ends. The edge map is held outside the block. It is read with combinational reads: the block drives eight linear addresses and receives eight bits in the same cycle.

The control is a five-state machine:
- `ST_IDLE` waits for a start pulse (the start transition).
- `ST_LOAD` clears the vote and loads the generator (the load-to-trace transition).
- `ST_TRACE` accumulates one step per cycle and leaves on the octant end (the trace-to-judge transition).
- `ST_JUDGE` compares the vote and moves to the next candidate. It goes back to `ST_LOAD` on the next-candidate transition, or on to `ST_FINISH` on the last-candidate transition.
- `ST_FINISH` pulses done and returns to `ST_IDLE` (the finish transition).

Top module: `hough_circle_voter`

## Requirements
- R1: After reset, `busy`, `done`, `best_cx`, `best_cy`, `best_r` and `best_votes` are all zero.
- R2: The offset generator starts at (x=0, y=r) with decision term 1-r. It emits the current (x,y) while x<=y. If the term is negative, only x advances and the term gains 2x+3. Otherwise both x advances and y retreats, and the term gains 2(x-y)+5. All eight mirrored reads of every emitted offset count, duplicates included: radius 0 over a set centre pixel gives 8 votes, and a drawn radius-3 circle gives 24.
- R3: The eight points of offset (x,y) are (cx±x, cy±y) and (cx±y, cy±x). Lane k drives the linear address row*IMG_W+column on `rd_addr[k*AW +: AW]`, and the bit for lane k returns on `rd_bit[k]`.
- R4: A point with a column outside 0..IMG_W-1 or a row outside 0..IMG_H-1 adds zero to the vote, whatever its lane reads.
- R5: Each candidate's vote starts from zero and equals the sum of its valid reads over the whole outline.
- R6: A candidate replaces the best only if its vote is strictly greater. The best starts as the first candidate with vote zero, so ties keep the earlier candidate.
- R7: Candidates are visited with the radius innermost, the centre column next and the centre row outermost, each over its inclusive range from low to high.
- R8: A candidate whose outline has S steps takes S+2 cycles. `done` is a one-cycle pulse in the cycle after the last candidate's judgement, which is T+1 cycles after the start edge, where T is the sum of S+2 over all candidates.
- R9: `busy` is high from the cycle after an accepted start through the done cycle. While the block is idle and no start is given, all result outputs hold their values.
- R10: While busy, `start` and every range input are ignored. The ranges are captured only by an accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a search when idle |
| cx_lo | input | XW (5) | Lowest centre column |
| cx_hi | input | XW (5) | Highest centre column |
| cy_lo | input | YW (5) | Lowest centre row |
| cy_hi | input | YW (5) | Highest centre row |
| r_lo | input | R_W (5) | Smallest radius |
| r_hi | input | R_W (5) | Largest radius |
| rd_addr | output | 8*AW (80) | Eight linear read addresses, lane k in bits k*AW +: AW |
| rd_bit | input | 8 | Edge bits returned for the eight lanes |
| best_cx | output | XW (5) | Winning centre column |
| best_cy | output | YW (5) | Winning centre row |
| best_r | output | R_W (5) | Winning radius |
| best_votes | output | VOTE_W (9) | Vote of the winning circle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a tie between two complete, equal-scoring circles. Several weaker candidates lie between them, so a comparison that allows equality would hand the win to the later circle. The stimulus draws two identical radius-4 outlines on the same row and sweeps the centre column across both, so the earlier one must survive. Out-of-bounds masking is provoked by a map whose only set pixel is at address zero, where any unmasked off-image lane would land. Diagonal and axis duplicates are exercised with small radii whose vote totals are fixed by hand.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
    localparam int LANES = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_TRACE,
        ST_JUDGE,
        ST_FINISH
    } hcv_state_e;
endpackage

// File: rtl/hcv_octant.sv
module hcv_octant #(
    parameter int R_W = 5,
    parameter int SW  = 7,
    parameter int DW  = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 adv,
    input  logic [R_W-1:0]       radius,
    output logic signed [SW-1:0] ox,
    output logic signed [SW-1:0] oy,
    output logic                 last_pt
);
    logic signed [DW-1:0] dterm;
    logic signed [DW-1:0] nd;
    logic signed [DW-1:0] xe;
    logic signed [DW-1:0] ye;
    logic signed [SW-1:0] nx;
    logic signed [SW-1:0] ny;

    assign xe = DW'(ox);
    assign ye = DW'(oy);

    always_comb begin
        nx = ox + SW'(1);
        if (dterm < 0) begin
            ny = oy;
            nd = dterm + (xe <<< 1) + DW'(3);
        end else begin
            ny = oy - SW'(1);
            nd = dterm + ((xe - ye) <<< 1) + DW'(5);
        end
    end

    assign last_pt = (nx > ny);

    always_ff @(posedge clk) begin
        if (rst) begin
            ox    <= '0;
            oy    <= '0;
            dterm <= '0;
        end else if (load) begin
            ox    <= '0;
            oy    <= SW'(radius);
            dterm <= DW'(1) - DW'(radius);
        end else if (adv) begin
            ox    <= nx;
            oy    <= ny;
            dterm <= nd;
        end
    end
endmodule

// File: rtl/hcv_mirror.sv
module hcv_mirror #(
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    parameter int XW    = 5,
    parameter int YW    = 5,
    parameter int SW    = 7,
    parameter int AW    = 10
) (
    input  logic [XW-1:0]        cx,
    input  logic [YW-1:0]        cy,
    input  logic signed [SW-1:0] ox,
    input  logic signed [SW-1:0] oy,
    output logic [8*AW-1:0]      addr,
    output logic [7:0]           valid
);
    localparam logic signed [SW-1:0] W_LIM = SW'(IMG_W);
    localparam logic signed [SW-1:0] H_LIM = SW'(IMG_H);
    localparam logic [AW-1:0]        W_A   = AW'(IMG_W);

    logic signed [SW-1:0] cxs;
    logic signed [SW-1:0] cys;

    assign cxs = $signed(SW'(cx));
    assign cys = $signed(SW'(cy));

    for (genvar k = 0; k < 8; k++) begin : g_lane
        localparam bit SWP  = (k >= 4);
        localparam bit NEGX = (k % 2) == 1;
        localparam bit NEGY = ((k / 2) % 2) == 1;

        logic signed [SW-1:0] dx;
        logic signed [SW-1:0] dy;
        logic signed [SW-1:0] px;
        logic signed [SW-1:0] py;
        logic                 inb;

        assign dx = SWP ? oy : ox;
        assign dy = SWP ? ox : oy;

        if (NEGX) begin : g_nx
            assign px = cxs - dx;
        end else begin : g_px
            assign px = cxs + dx;
        end

        if (NEGY) begin : g_ny
            assign py = cys - dy;
        end else begin : g_py
            assign py = cys + dy;
        end

        assign inb = (px >= 0) && (px < W_LIM) && (py >= 0) && (py < H_LIM);
        assign valid[k] = inb;
        assign addr[k*AW +: AW] = inb ?
            (AW'(py[YW-1:0]) * W_A + AW'(px[XW-1:0])) : '0;
    end
endmodule

// File: rtl/hcv_tally.sv
module hcv_tally (
    input  logic [7:0] valid,
    input  logic [7:0] bits,
    output logic [3:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int k = 0; k < 8; k++) begin
            cnt = cnt + {3'b000, valid[k] & bits[k]};
        end
    end
endmodule

// File: rtl/hough_circle_voter.sv
module hough_circle_voter
    import hcv_pkg::*;
#(
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    parameter int R_W   = 5,
    localparam int XW     = $clog2(IMG_W),
    localparam int YW     = $clog2(IMG_H),
    localparam int AW     = $clog2(IMG_W * IMG_H),
    localparam int VOTE_W = R_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [XW-1:0]     cx_lo,
    input  logic [XW-1:0]     cx_hi,
    input  logic [YW-1:0]     cy_lo,
    input  logic [YW-1:0]     cy_hi,
    input  logic [R_W-1:0]    r_lo,
    input  logic [R_W-1:0]    r_hi,
    output logic [8*AW-1:0]   rd_addr,
    input  logic [7:0]        rd_bit,
    output logic [XW-1:0]     best_cx,
    output logic [YW-1:0]     best_cy,
    output logic [R_W-1:0]    best_r,
    output logic [VOTE_W-1:0] best_votes,
    output logic              busy,
    output logic              done
);
    localparam int MXY = (XW > YW) ? XW : YW;
    localparam int MAXW = (MXY > R_W) ? MXY : R_W;
    localparam int SW = MAXW + 2;
    localparam int DW = SW + 2;

    hcv_state_e state;
    hcv_state_e nxt;

    logic [XW-1:0]  cx_lo_q, cx_hi_q, cx_c;
    logic [YW-1:0]  cy_lo_q, cy_hi_q, cy_c;
    logic [R_W-1:0] r_lo_q, r_hi_q, r_c;
    logic [VOTE_W-1:0] vote_acc;

    logic signed [SW-1:0] ox, oy;
    logic                 last_pt;
    logic [7:0]           lane_ok;
    logic [3:0]           step_cnt;
    logic                 last_cand;

    hcv_octant #(.R_W(R_W), .SW(SW), .DW(DW)) u_oct (
        .clk    (clk),
        .rst    (rst),
        .load   (state == ST_LOAD),
        .adv    (state == ST_TRACE),
        .radius (r_c),
        .ox     (ox),
        .oy     (oy),
        .last_pt(last_pt)
    );

    hcv_mirror #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW), .SW(SW), .AW(AW)
    ) u_mir (
        .cx   (cx_c),
        .cy   (cy_c),
        .ox   (ox),
        .oy   (oy),
        .addr (rd_addr),
        .valid(lane_ok)
    );

    hcv_tally u_tal (
        .valid(lane_ok),
        .bits (rd_bit),
        .cnt  (step_cnt)
    );

    assign last_cand = (r_c >= r_hi_q) && (cx_c >= cx_hi_q) && (cy_c >= cy_hi_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_LOAD;
            ST_LOAD:   nxt = ST_TRACE;
            ST_TRACE:  if (last_pt) nxt = ST_JUDGE;
            ST_JUDGE:  nxt = last_cand ? ST_FINISH : ST_LOAD;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // status outputs
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_FINISH);
    end

    // candidate, vote and best-circle datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cx_lo_q <= '0; cx_hi_q <= '0; cx_c <= '0;
            cy_lo_q <= '0; cy_hi_q <= '0; cy_c <= '0;
            r_lo_q  <= '0; r_hi_q  <= '0; r_c  <= '0;
            vote_acc   <= '0;
            best_cx    <= '0;
            best_cy    <= '0;
            best_r     <= '0;
            best_votes <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cx_lo_q <= cx_lo; cx_hi_q <= cx_hi; cx_c <= cx_lo;
                        cy_lo_q <= cy_lo; cy_hi_q <= cy_hi; cy_c <= cy_lo;
                        r_lo_q  <= r_lo;  r_hi_q  <= r_hi;  r_c  <= r_lo;
                        best_cx    <= cx_lo;
                        best_cy    <= cy_lo;
                        best_r     <= r_lo;
                        best_votes <= '0;
                    end
                end
                ST_LOAD: vote_acc <= '0;
                ST_TRACE: vote_acc <= vote_acc + VOTE_W'(step_cnt);
                ST_JUDGE: begin
                    if (vote_acc > best_votes) begin
                        best_cx    <= cx_c;
                        best_cy    <= cy_c;
                        best_r     <= r_c;
                        best_votes <= vote_acc;
                    end
                    if (r_c < r_hi_q) begin
                        r_c <= r_c + 1'b1;
                    end else begin
                        r_c <= r_lo_q;
                        if (cx_c < cx_hi_q) begin
                            cx_c <= cx_c + 1'b1;
                        end else begin
                            cx_c <= cx_lo_q;
                            cy_c <= cy_c + 1'b1;
                        end
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hcv_checker.sv
module hcv_checker #(
    parameter int XW     = 5,
    parameter int YW     = 5,
    parameter int R_W    = 5,
    parameter int VOTE_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [XW-1:0]     best_cx,
    input logic [YW-1:0]     best_cy,
    input logic [R_W-1:0]    best_r,
    input logic [VOTE_W-1:0] best_votes
);
    // R8: done lasts one cycle and the block is idle afterwards
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R9: a search only begins after a start request
    assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R9: results hold while idle with no start
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(best_cx) && $stable(best_cy)
                               && $stable(best_r) && $stable(best_votes)));

    // R6: the best vote never falls during a search
    assert_best_monotone_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> (best_votes >= $past(best_votes)));
endmodule

bind hough_circle_voter hcv_checker #(
    .XW(XW), .YW(YW), .R_W(R_W), .VOTE_W(VOTE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .best_cx   (best_cx),
    .best_cy   (best_cy),
    .best_r    (best_r),
    .best_votes(best_votes)
);

// File: tb/sim_hough_circle_voter.sv
module sim_hough_circle_voter;
    localparam int CLK_P  = 10;
    localparam int IMG_W  = 32;
    localparam int IMG_H  = 32;
    localparam int R_W    = 5;
    localparam int XW     = 5;
    localparam int YW     = 5;
    localparam int AW     = 10;
    localparam int VOTE_W = 9;
    localparam int WAIT_LIM = 60000;

    // stimulus vectors: map kind, drawn circle, search ranges
    // kind 0 empty, 1 all set, 2 one drawn circle, 3 only pixel (0,0)
    localparam int ROWS = 5;
    localparam int T_KIND[ROWS] = '{2, 1, 0, 3, 2};
    localparam int T_DX[ROWS]   = '{12, 0, 0, 0, 25};
    localparam int T_DY[ROWS]   = '{14, 0, 0, 0, 6};
    localparam int T_DR[ROWS]   = '{5, 0, 0, 0, 7};
    localparam int T_CXL[ROWS]  = '{8, 0, 5, 1, 22};
    localparam int T_CXH[ROWS]  = '{16, 2, 7, 1, 28};
    localparam int T_CYL[ROWS]  = '{10, 0, 5, 1, 3};
    localparam int T_CYH[ROWS]  = '{18, 2, 6, 1, 9};
    localparam int T_RL[ROWS]   = '{3, 2, 1, 3, 5};
    localparam int T_RH[ROWS]   = '{7, 4, 2, 3, 9};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [XW-1:0] cx_lo = '0, cx_hi = '0;
    logic [YW-1:0] cy_lo = '0, cy_hi = '0;
    logic [R_W-1:0] r_lo = '0, r_hi = '0;
    logic [8*AW-1:0] rd_addr;
    logic [7:0] rd_bit;
    logic [XW-1:0] best_cx;
    logic [YW-1:0] best_cy;
    logic [R_W-1:0] best_r;
    logic [VOTE_W-1:0] best_votes;
    logic busy, done;

    logic [IMG_W*IMG_H-1:0] emap = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int exp_cx, exp_cy, exp_r, exp_v, exp_t;

    always #(CLK_P/2) clk = ~clk;

    for (genvar k = 0; k < 8; k++) begin : g_mem
        assign rd_bit[k] = emap[rd_addr[k*AW +: AW]];
    end

    hough_circle_voter #(.IMG_W(IMG_W), .IMG_H(IMG_H), .R_W(R_W)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .cx_lo(cx_lo), .cx_hi(cx_hi), .cy_lo(cy_lo), .cy_hi(cy_hi),
        .r_lo(r_lo), .r_hi(r_hi),
        .rd_addr(rd_addr), .rd_bit(rd_bit),
        .best_cx(best_cx), .best_cy(best_cy), .best_r(best_r),
        .best_votes(best_votes), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit inb(input int px, input int py);
        return (px >= 0) && (px < IMG_W) && (py >= 0) && (py < IMG_H);
    endfunction

    function automatic int pix(input int px, input int py);
        if (!inb(px, py)) return 0;
        return int'(emap[py*IMG_W + px]);
    endfunction

    task automatic setpix(input int px, input int py);
        if (inb(px, py)) emap[py*IMG_W + px] = 1'b1;
    endtask

    task automatic draw_circle(input int cx, input int cy, input int r);
        int x, y, d;
        x = 0; y = r; d = 1 - r;
        while (x <= y) begin
            setpix(cx+x, cy+y); setpix(cx-x, cy+y);
            setpix(cx+x, cy-y); setpix(cx-x, cy-y);
            setpix(cx+y, cy+x); setpix(cx-y, cy+x);
            setpix(cx+y, cy-x); setpix(cx-y, cy-x);
            if (d < 0) d = d + 2*x + 3;
            else begin d = d + 2*(x-y) + 5; y = y - 1; end
            x = x + 1;
        end
    endtask

    function automatic int circ_votes(input int cx, input int cy, input int r);
        int x, y, d, v;
        x = 0; y = r; d = 1 - r; v = 0;
        while (x <= y) begin
            v += pix(cx+x, cy+y) + pix(cx-x, cy+y) + pix(cx+x, cy-y) + pix(cx-x, cy-y);
            v += pix(cx+y, cy+x) + pix(cx-y, cy+x) + pix(cx+y, cy-x) + pix(cx-y, cy-x);
            if (d < 0) d = d + 2*x + 3;
            else begin d = d + 2*(x-y) + 5; y = y - 1; end
            x = x + 1;
        end
        return v;
    endfunction

    function automatic int circ_steps(input int r);
        int x, y, d, s;
        x = 0; y = r; d = 1 - r; s = 0;
        while (x <= y) begin
            s++;
            if (d < 0) d = d + 2*x + 3;
            else begin d = d + 2*(x-y) + 5; y = y - 1; end
            x = x + 1;
        end
        return s;
    endfunction

    task automatic model(input int cxl, input int cxh, input int cyl, input int cyh,
                         input int rl, input int rh);
        exp_cx = cxl; exp_cy = cyl; exp_r = rl; exp_v = 0; exp_t = 0;
        for (int cy = cyl; cy <= cyh; cy++)
            for (int cx = cxl; cx <= cxh; cx++)
                for (int r = rl; r <= rh; r++) begin
                    int v;
                    v = circ_votes(cx, cy, r);
                    exp_t += circ_steps(r) + 2;
                    if (v > exp_v) begin
                        exp_v = v; exp_cx = cx; exp_cy = cy; exp_r = r;
                    end
                end
    endtask

    // returns the number of falling edges from the start edge to done
    task automatic launch(input int cxl, input int cxh, input int cyl, input int cyh,
                          input int rl, input int rh, input bit poke, output int n);
        @(negedge clk);
        cx_lo = XW'(cxl); cx_hi = XW'(cxh);
        cy_lo = YW'(cyl); cy_hi = YW'(cyh);
        r_lo = R_W'(rl);  r_hi = R_W'(rh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < WAIT_LIM) begin
            if (poke && n == 20) begin
                start = 1'b1;
                cx_lo = '0; cx_hi = '0; cy_lo = '0; cy_hi = '0;
                r_lo = 1; r_hi = 1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (!done) chk(1'b0, "watchdog", n, WAIT_LIM);
    endtask

    task automatic full_check(input int cxl, input int cxh, input int cyl, input int cyh,
                              input int rl, input int rh, input bit poke);
        int n;
        logic [XW-1:0] hcx;
        logic [VOTE_W-1:0] hv;
        model(cxl, cxh, cyl, cyh, rl, rh);
        launch(cxl, cxh, cyl, cyh, rl, rh, poke, n);
        chk(int'(best_cx) == exp_cx, "R7 best_cx", int'(best_cx), exp_cx);
        chk(int'(best_cy) == exp_cy, "R7 best_cy", int'(best_cy), exp_cy);
        chk(int'(best_r) == exp_r, "R7 best_r", int'(best_r), exp_r);
        chk(int'(best_votes) == exp_v, "R5 best_votes", int'(best_votes), exp_v);
        chk(n == exp_t + 1, "R8 latency", n, exp_t + 1);
        hcx = best_cx; hv = best_votes;
        @(negedge clk);
        chk(!done, "R8 done pulse width", int'(done), 0);
        repeat (8) @(negedge clk);
        chk(!busy && !done, "R9 idle after search", int'(busy), 0);
        chk(best_cx == hcx && best_votes == hv, "R9 outputs held", int'(best_votes), int'(hv));
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 busy/done after reset", int'(busy) + int'(done), 0);
        chk(best_cx == 0 && best_cy == 0 && best_r == 0 && best_votes == 0,
            "R1 results after reset", int'(best_votes) + int'(best_r), 0);

        // table walk
        for (int i = 0; i < ROWS; i++) begin
            emap = '0;
            case (T_KIND[i])
                1: emap = '1;
                2: draw_circle(T_DX[i], T_DY[i], T_DR[i]);
                3: emap[0] = 1'b1;
                default: ;
            endcase
            full_check(T_CXL[i], T_CXH[i], T_CYL[i], T_CYH[i], T_RL[i], T_RH[i], 1'b0);
        end

        // R2: radius 0, centre pixel read by all eight lanes
        emap = '0; setpix(10, 10);
        full_check(10, 10, 10, 10, 0, 0, 1'b0);
        chk(int'(best_votes) == 8, "R2 radius zero votes", int'(best_votes), 8);

        // R2: radius 3 outline, diagonal duplicates counted
        emap = '0; draw_circle(15, 15, 3);
        full_check(15, 15, 15, 15, 3, 3, 1'b0);
        chk(int'(best_votes) == 24, "R2 radius three votes", int'(best_votes), 24);

        // R3: two single pixels hit by distinct mirrored lanes
        emap = '0; setpix(11, 7); setpix(7, 11);
        full_check(10, 10, 10, 10, 3, 3, 1'b0);
        chk(int'(best_votes) == 2, "R3 mirrored points", int'(best_votes), 2);

        // R4: off-image lanes must not read address zero
        emap = '0; emap[0] = 1'b1;
        full_check(1, 1, 1, 1, 3, 3, 1'b0);
        chk(int'(best_votes) == 0, "R4 out of bounds masked", int'(best_votes), 0);

        // R6: tie between two equal circles keeps the earlier one
        emap = '0; draw_circle(8, 10, 4); draw_circle(20, 10, 4);
        full_check(8, 20, 10, 10, 4, 4, 1'b0);
        chk(int'(best_cx) == 8, "R6 tie keeps earlier", int'(best_cx), 8);
        chk(int'(best_votes) == 32, "R6 tie vote", int'(best_votes), 32);

        // R10: start and new ranges while busy are ignored
        emap = '0; draw_circle(12, 14, 5);
        full_check(10, 12, 12, 14, 4, 6, 1'b1);
        chk(int'(best_r) == 5 && int'(best_cx) == 12, "R10 mid-run start ignored",
            int'(best_r), 5);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule